// File: doc/BRIEF.md
# Serial Link Transmit Frame Selector

This block sits in front of a serial-link transmitter. On every word clock it decides what goes out next: a data frame, a control frame, or an idle fill frame. The idle fill frame is what keeps the far-end receiver locked whenever there is nothing to send. The result is a registered 20-bit frame with four fields: a frame-type code, a flag bit, a 16-bit payload and an inversion bit. A frame-valid strobe accompanies it. The serializer downstream shifts the frame out.

The block keeps a running line balance, the count of ones minus zeros over every payload and inversion bit it has emitted. It uses this balance in two places:

- For data and control words, it inverts the payload when sending it unchanged would push the balance further from zero.
- For type-1 idle fill, it picks between two complementary variants, choosing the one that steers the balance back toward zero.

The flag bit of a data or control frame has two modes. It can carry one extra bit of user data. Otherwise the block alternates it on its own, so the receiver can spot lost or duplicated frames.

Top module: `link_tx_framer`

## Requirements
- R1: A fill frame is produced for every word cycle in which `enData` is low, or in which both `ctrlAvail` and `dataAvail` are low. No gap occurs, however long the idle run lasts.
- R2: The frame layout is: `frameOut[19:18]` is the type, `frameOut[17]` is the flag, `frameOut[16:1]` is the payload, and `frameOut[0]` is the inversion bit. The type codes are data = 01, control = 10, type-0 fill = 00 and type-1 fill = 11. When `enData` is high and `ctrlAvail` is high, a control frame is sent, whatever the state of `dataAvail`.
- R3: With `fillSel` low, every fill frame has type 00, flag 0, payload 16'h5555 and inversion bit 0.
- R4: With `fillSel` high, a fill frame has type 11 and flag 0. Its payload and inversion bit depend on the balance:
  - balance zero or positive: variant A, payload 16'hFF00 with inversion bit 0;
  - balance negative: variant B, payload 16'h00FF with inversion bit 1.
- R5: The balance is a signed 8-bit value. Reset sets it to 0. Each emitted frame adds (ones − zeros) over its 16 payload bits and its inversion bit. The result saturates at −128 and +127 instead of wrapping.
- R6: For a data or control frame, the block first computes the contribution the unchanged word would make, with the inversion bit at 0. If that contribution has the same nonzero sign as the current balance, the payload goes out bitwise inverted with the inversion bit at 1. Otherwise the payload goes out unchanged with the inversion bit at 0.
- R7: When `flagMode` is high, the flag bit of each data or control frame equals `flagIn` as sampled with that word.
- R8: When `flagMode` is low, `flagIn` is ignored. The flag bit of the first data or control frame after reset is 0, and it inverts on every further data or control frame sent in this mode. Fill frames, and frames sent with `flagMode` high, leave the alternation where it was.
- R9: While `rst` is high, `frameOut` is all zero and `frameValid` is low. After reset, each frame appears on the clock edge following the edge that sampled its inputs, and `frameValid` is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 16 | Data or control word to send |
| ctrlAvail | input | 1 | A control word is offered this cycle |
| dataAvail | input | 1 | A data word is offered this cycle |
| enData | input | 1 | Qualifier; low forces fill frames |
| fillSel | input | 1 | Fill type: 0 = type-0, 1 = type-1 |
| flagIn | input | 1 | Extra user bit for the flag field |
| flagMode | input | 1 | 1 = flag carries `flagIn`, 0 = automatic alternation |
| frameOut | output | 20 | Registered frame {type, flag, payload, inversion} |
| frameValid | output | 1 | High on every cycle a frame is presented |

## Verification
The embedded properties watch the following on every cycle:
- idle words turn into fill frames, and control wins over data;
- a type-0 fill always carries its fixed pattern, and a type-1 fill variant follows the sign of the balance held one cycle earlier;
- consecutive automatic-mode frames carry opposite flags, the alternation stays frozen across fills, and a transparent flag matches the sampled input;
- the valid strobe stays high outside reset.

The exact amount the balance moves is checked only by the bench's reference model. The same holds for the inversion choice on particular words, saturation after a long type-0 idle run, and the flag sequence resuming correctly after fills and mode changes.

// File: rtl/link_tx_pkg.sv
package link_tx_pkg;

  localparam logic [1:0] TYPE_FILL0 = 2'b00;
  localparam logic [1:0] TYPE_DATA  = 2'b01;
  localparam logic [1:0] TYPE_CTRL  = 2'b10;
  localparam logic [1:0] TYPE_FILL1 = 2'b11;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic pickCtrl;
    logic pickData;
    logic pickFill0;
    logic pickFill1;
    logic flagBit;
  } txSel_t;

endpackage

// File: rtl/link_tx_ctrl.sv
module link_tx_ctrl
  import link_tx_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   ctrlAvail,
  input  logic   dataAvail,
  input  logic   enData,
  input  logic   fillSel,
  input  logic   flagIn,
  input  logic   flagMode,
  output txSel_t sel
);

  logic toggleQ;
  logic isIdle;

  always_comb begin
    isIdle = !enData || !(ctrlAvail || dataAvail);
    sel = '0;
    if (isIdle) begin
      sel.pickFill1 = fillSel;
      sel.pickFill0 = !fillSel;
    end else if (ctrlAvail) begin
      sel.pickCtrl = 1'b1;
    end else begin
      sel.pickData = 1'b1;
    end
    sel.flagBit = isIdle ? 1'b0 : (flagMode ? flagIn : toggleQ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      toggleQ <= 1'b0;
    end else if (!isIdle && !flagMode) begin
      toggleQ <= ~toggleQ;
    end
  end

  AST_TOGGLE_FROZEN_ON_FILL: assert property (@(posedge clk) disable iff (rst)
    isIdle |=> $stable(toggleQ)); // R8

endmodule

// File: rtl/link_tx_datapath.sv
module link_tx_datapath
  import link_tx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  txSel_t            sel,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W+3:0] frameOut,
  output logic              frameValid
);

  localparam int BODY_W = DATA_W + 1;
  localparam int CNT_W  = $clog2(BODY_W + 1);
  localparam int SUM_W  = DISP_W + CNT_W + 2;
  localparam logic [DATA_W-1:0] FILL0_PAT  = {(DATA_W/2){2'b01}};
  localparam logic [DATA_W-1:0] FILL1A_PAT = {{(DATA_W/2){1'b1}}, {(DATA_W/2){1'b0}}};
  localparam logic signed [SUM_W-1:0] DISP_MAX = SUM_W'(2**(DISP_W-1) - 1);
  localparam logic signed [SUM_W-1:0] DISP_MIN = -DISP_MAX - SUM_W'(1);

  function automatic logic [CNT_W-1:0] countOnes(input logic [BODY_W-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < BODY_W; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  logic signed [DISP_W-1:0] disp;
  logic signed [SUM_W-1:0]  dispExt, rawDelta, outDelta, sumNext, rawOnesExt, outOnesExt;
  logic [CNT_W-1:0]         rawOnes, outOnes;
  logic                     dispNeg, wantInvert, invBit;
  logic [DATA_W-1:0]        payload;
  logic [1:0]               typeCode;

  always_comb begin
    dispExt    = SUM_W'(disp);
    dispNeg    = disp[DISP_W-1];
    rawOnes    = countOnes({dataIn, 1'b0});
    rawOnesExt = SUM_W'(rawOnes);
    rawDelta   = (rawOnesExt <<< 1) - SUM_W'(BODY_W);
    wantInvert = ((dispExt > 0) && (rawDelta > 0)) || ((dispExt < 0) && (rawDelta < 0));

    if (sel.pickFill0) begin
      payload = FILL0_PAT;
      invBit  = 1'b0;
    end else if (sel.pickFill1) begin
      payload = dispNeg ? ~FILL1A_PAT : FILL1A_PAT;
      invBit  = dispNeg;
    end else begin
      payload = wantInvert ? ~dataIn : dataIn;
      invBit  = wantInvert;
    end

    if (sel.pickCtrl)       typeCode = TYPE_CTRL;
    else if (sel.pickData)  typeCode = TYPE_DATA;
    else if (sel.pickFill1) typeCode = TYPE_FILL1;
    else                    typeCode = TYPE_FILL0;

    outOnes    = countOnes({payload, invBit});
    outOnesExt = SUM_W'(outOnes);
    outDelta   = (outOnesExt <<< 1) - SUM_W'(BODY_W);
    sumNext    = dispExt + outDelta;
    if (sumNext > DISP_MAX)      sumNext = DISP_MAX;
    else if (sumNext < DISP_MIN) sumNext = DISP_MIN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp       <= '0;
      frameOut   <= '0;
      frameValid <= 1'b0;
    end else begin
      disp       <= DISP_W'(sumNext);
      frameOut   <= {typeCode, sel.flagBit, payload, invBit};
      frameValid <= 1'b1;
    end
  end

  AST_VALID_STEADY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> frameValid); // R9

  AST_FILL0_PATTERN: assert property (@(posedge clk) disable iff (rst)
    (frameValid && frameOut[DATA_W+3:DATA_W+2] == TYPE_FILL0)
      |-> (frameOut[DATA_W:0] == {FILL0_PAT, 1'b0} && !frameOut[DATA_W+1])); // R3

  AST_FILL1_VARIANT: assert property (@(posedge clk) disable iff (rst)
    (frameValid && frameOut[DATA_W+3:DATA_W+2] == TYPE_FILL1)
      |-> ((frameOut[DATA_W:1] == FILL1A_PAT) == !$past(disp[DISP_W-1]))); // R4

endmodule

// File: rtl/link_tx_framer.sv
module link_tx_framer
  import link_tx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              ctrlAvail,
  input  logic              dataAvail,
  input  logic              enData,
  input  logic              fillSel,
  input  logic              flagIn,
  input  logic              flagMode,
  output logic [DATA_W+3:0] frameOut,
  output logic              frameValid
);

  localparam int TYPE_HI = DATA_W + 3;
  localparam int FLAG_AT = DATA_W + 1;

  txSel_t sel;

  link_tx_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ctrlAvail(ctrlAvail),
    .dataAvail(dataAvail),
    .enData   (enData),
    .fillSel  (fillSel),
    .flagIn   (flagIn),
    .flagMode (flagMode),
    .sel      (sel)
  );

  link_tx_datapath #(
    .DATA_W(DATA_W),
    .DISP_W(DISP_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel),
    .dataIn    (dataIn),
    .frameOut  (frameOut),
    .frameValid(frameValid)
  );

  logic busyWord;
  logic busyAuto;
  assign busyWord = enData && (ctrlAvail || dataAvail);
  assign busyAuto = busyWord && !flagMode;

  AST_IDLE_FILL: assert property (@(posedge clk) disable iff (rst)
    !busyWord |=> (frameOut[TYPE_HI] == frameOut[TYPE_HI-1])); // R1

  AST_CTRL_FIRST: assert property (@(posedge clk) disable iff (rst)
    (enData && ctrlAvail) |=> (frameOut[TYPE_HI:TYPE_HI-1] == TYPE_CTRL)); // R2

  AST_FLAG_CARRIED: assert property (@(posedge clk) disable iff (rst)
    (busyWord && flagMode) |=> (frameOut[FLAG_AT] == $past(flagIn))); // R7

  AST_FLAG_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    busyAuto ##1 busyAuto |=> (frameOut[FLAG_AT] != $past(frameOut[FLAG_AT]))); // R8

endmodule

// File: tb/link_tx_framer_tb.sv
`timescale 1ns/1ps
module link_tx_framer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] dataIn = '0;
  logic        ctrlAvail = 1'b0, dataAvail = 1'b0, enData = 1'b0;
  logic        fillSel = 1'b0, flagIn = 1'b0, flagMode = 1'b0;
  logic [19:0] frameOut;
  logic        frameValid;

  int checks = 0;
  int errors = 0;
  int mDisp  = 0;
  bit mTog   = 1'b0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  link_tx_framer u_dut (
    .clk(clk), .rst(rst), .dataIn(dataIn), .ctrlAvail(ctrlAvail),
    .dataAvail(dataAvail), .enData(enData), .fillSel(fillSel),
    .flagIn(flagIn), .flagMode(flagMode), .frameOut(frameOut),
    .frameValid(frameValid)
  );

  task automatic checkVal(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one word cycle: drive at negedge, sample at the following negedge
  task automatic step(input string tag, input bit ca, input bit da, input bit en,
                      input bit fs, input bit fi, input bit fm, input logic [15:0] d);
    logic [1:0]  ty;
    logic        fl, iv;
    logic [15:0] pl;
    int          d0;
    ctrlAvail = ca; dataAvail = da; enData = en;
    fillSel = fs; flagIn = fi; flagMode = fm; dataIn = d;
    if (!en || !(ca || da)) begin
      fl = 1'b0;
      if (fs) begin
        ty = 2'b11;
        pl = (mDisp < 0) ? 16'h00FF : 16'hFF00;
        iv = (mDisp < 0);
      end else begin
        ty = 2'b00; pl = 16'h5555; iv = 1'b0;
      end
    end else begin
      ty = ca ? 2'b10 : 2'b01;
      fl = fm ? fi : mTog;
      if (!fm) mTog = !mTog;
      d0 = 2 * $countones(d) - 17;
      iv = (mDisp > 0 && d0 > 0) || (mDisp < 0 && d0 < 0);
      pl = iv ? ~d : d;
    end
    mDisp = mDisp + 2 * $countones({pl, iv}) - 17;
    if (mDisp > 127)  mDisp = 127;
    if (mDisp < -128) mDisp = -128;
    @(posedge clk);
    @(negedge clk);
    checkVal(tag, frameOut, {ty, fl, pl, iv});
    checkVal({tag, " valid"}, {19'd0, frameValid}, 20'd1);
  endtask

  task automatic tReset;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checkVal("R9 reset frame", frameOut, 20'd0);
    checkVal("R9 reset valid", {19'd0, frameValid}, 20'd0);
    mDisp = 0; mTog = 1'b0;
    rst = 1'b0;
  endtask

  task automatic tFill0Run;
    for (int i = 0; i < 6; i++) step("R1 R3 fill0 idle", 0, 0, 1, 0, 1, 0, 16'h1234);
  endtask

  task automatic tFill1Balance;
    // balance now negative from fill0 run: expect variant B, then A at zero
    for (int i = 0; i < 10; i++) step("R4 fill1 variant", 0, 0, 1, 1, 0, 0, 16'h0);
  endtask

  task automatic tInversion;
    step("R6 first FFFF plain", 0, 1, 1, 0, 0, 1, 16'hFFFF);
    step("R6 second FFFF inverted", 0, 1, 1, 0, 0, 1, 16'hFFFF);
    step("R6 zero word", 0, 1, 1, 0, 0, 1, 16'h0000);
    step("R6 zero word again", 0, 1, 1, 0, 0, 1, 16'h0000);
    step("R6 mixed", 0, 1, 1, 0, 0, 1, 16'h0F0F);
    step("R5 R6 dense", 1, 0, 1, 0, 0, 1, 16'hFFF0);
  endtask

  task automatic tPriority;
    step("R2 both avail ctrl wins", 1, 1, 1, 0, 0, 1, 16'hA5A5);
    step("R2 data only", 0, 1, 1, 0, 0, 1, 16'h5A5A);
    step("R2 ctrl only", 1, 0, 1, 0, 0, 1, 16'h3C3C);
  endtask

  task automatic tEnGate;
    step("R1 enData low blocks ctrl", 1, 1, 0, 0, 0, 0, 16'hBEEF);
    step("R1 enData low fill1", 0, 1, 0, 1, 0, 0, 16'hBEEF);
  endtask

  task automatic tFlagTransparent;
    step("R7 flag one", 0, 1, 1, 0, 1, 1, 16'h1111);
    step("R7 flag zero", 0, 1, 1, 0, 0, 1, 16'h2222);
    step("R7 flag one ctrl", 1, 0, 1, 0, 1, 1, 16'h4444);
  endtask

  task automatic tFlagAuto;
    step("R8 auto first", 0, 1, 1, 0, 1, 0, 16'h1357);
    step("R8 auto second", 0, 1, 1, 0, 1, 0, 16'h2468);
    step("R8 fill holds", 0, 0, 1, 1, 1, 0, 16'h0);
    step("R8 fill holds 2", 0, 0, 0, 0, 1, 0, 16'h0);
    step("R8 auto third", 1, 0, 1, 0, 0, 0, 16'hCAFE);
    step("R8 transparent holds", 0, 1, 1, 0, 1, 1, 16'h0001);
    step("R8 auto fourth", 0, 1, 1, 0, 1, 0, 16'hF00D);
  endtask

  task automatic tSaturate;
    for (int i = 0; i < 140; i++) step("R5 long fill0", 0, 0, 1, 0, 0, 0, 16'h0);
    for (int i = 0; i < 132; i++) step("R5 R4 recover", 0, 0, 1, 1, 0, 0, 16'h0);
    step("R5 R6 after recover", 0, 1, 1, 0, 0, 1, 16'hFFFF);
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tReset();
    tFill0Run();
    tFill1Balance();
    tInversion();
    tPriority();
    tEnGate();
    tFlagTransparent();
    tFlagAuto();
    tReset();
    tFlagAuto();
    tReset();
    tSaturate();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule